// File: doc/BRIEF.md
# Host Bus DMA Request Generator

This block lives inside the slave side of a host local-bus interface. It drives a single request line that a host DMA controller can use as its trigger, so 32-bit words can be streamed through the host data port with little CPU involvement. Software sets up the block through a small control register that holds an enable bit and a direction bit. The request line is also readable as a status bit.

While the block is enabled, it counts every byte strobe on the host data port whose direction matches the configured direction. A word is complete after four counted bytes. The block then waits for a single-cycle ready pulse from the internal data path, which may arrive any number of cycles later. On that pulse it raises the request. The request stays high until the first counted byte of the following word.

A control-register write always clears the byte counter. Rewriting the enable bit while it is already set therefore restarts a stream that has lost word alignment. If an access in the wrong direction arrives in the middle of a word, a sticky error flag is raised.

Top module: `dmarq_top`

## Requirements
- R1: After synchronous reset, `cfg_en`, `cfg_dir`, `dma_req`, `stat_dreq` and `err_flag` are all 0, and the byte count is 0.
- R2: A cycle with `ctl_wr` = 1 loads `ctl_en_in` into `cfg_en` and `ctl_dir_in` into `cfg_dir`, both visible in the following cycle.
- R3: After the fourth counted byte of a word, `dma_req` rises in the cycle after the first `dn_rdy` pulse that arrives at least one cycle after that byte. A `dn_rdy` pulse with no completed word pending has no effect.
- R4: `dma_req` falls in the cycle after the first counted byte of the next word. The count wraps from 3 to 0, so each request needs four fresh counted bytes.
- R5: A byte strobe is counted only when `cfg_en` = 1 and `hb_dir` equals `cfg_dir`. Any other strobe leaves the count unchanged.
- R6: Any control write clears the byte count, any pending word, `dma_req` and `err_flag`. In particular, writing enable = 1 while already enabled restarts the four-byte sequence.
- R7: While `cfg_en` = 0, `dma_req` is 0 and neither byte strobes nor `dn_rdy` pulses can raise it.
- R8: `stat_dreq` always equals `dma_req`.
- R9: A byte strobe that arrives while enabled, with the wrong direction and a nonzero byte count (mid-word), sets `err_flag`. The flag stays set until a control write or reset.
- R10: Direction encoding is 0 = receive (host writes, `hb_dir` = 0) and 1 = transmit (host reads, `hb_dir` = 1). Both directions work identically apart from which strobes count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_en_in | input | 1 | Enable value written with `ctl_wr` |
| ctl_dir_in | input | 1 | Direction value written with `ctl_wr` (0 receive, 1 transmit) |
| hb_stb | input | 1 | One host data-port byte moved this cycle |
| hb_dir | input | 1 | Direction of that byte (0 host write, 1 host read) |
| dn_rdy | input | 1 | Single-cycle pulse: internal path ready for next word |
| dma_req | output | 1 | DMA request to host controller |
| stat_dreq | output | 1 | Status register bit mirroring the request |
| cfg_en | output | 1 | Current enable bit |
| cfg_dir | output | 1 | Current direction bit |
| err_flag | output | 1 | Sticky wrong-direction-mid-word error |

## Verification
The properties assume that `dn_rdy` is a clean single-cycle pulse and that the host waits for a request before it starts the next word. The bench drives all inputs for exactly one cycle at a time, away from the clock edge. It always issues ready pulses at least one cycle after the fourth byte, apart from the deliberate stray pulses that check R3. The only wrong-direction strobes are the ones that exercise R5 and R9, and a control write always precedes any change of direction.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } xfer_dir_e;

  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/dmarq_ctrl.sv
module dmarq_ctrl
  import dmarq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr,
  input  logic      en_in,
  input  logic      dir_in,
  input  logic      stb,
  input  logic      stb_dir,
  input  logic      mid_word,
  output logic      en,
  output xfer_dir_e dir,
  output logic      count_ok,
  output logic      err
);
  logic dir_match;

  assign dir_match = (stb_dir == dir);
  assign count_ok  = en && stb && dir_match && !wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      dir <= DIR_RX;
      err <= 1'b0;
    end else if (wr) begin
      en  <= en_in;
      dir <= xfer_dir_e'(dir_in);
      err <= 1'b0;
    end else if (en && stb && !dir_match && mid_word) begin
      err <= 1'b1;
    end
  end
endmodule

// File: rtl/dmarq_counter.sv
module dmarq_counter #(
  parameter int unsigned BYTES = 4,
  localparam int unsigned CW   = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  localparam logic [CW-1:0] LAST = CW'(BYTES - 1);

  assign wrap = inc && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dmarq_reqgen.sv
module dmarq_reqgen (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  input  logic word_done,
  input  logic rdy,
  output logic req
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pend <= 1'b0;
      req  <= 1'b0;
    end else begin
      if (word_done) begin
        pend <= 1'b1;
      end else if (pend && rdy) begin
        pend <= 1'b0;
        req  <= 1'b1;
      end
      if (inc && req) req <= 1'b0;
    end
  end
endmodule

// File: rtl/dmarq_top.sv
module dmarq_top
  import dmarq_pkg::*;
#(
  parameter int unsigned BYTES = WORD_BYTES
) (
  input  logic clk,
  input  logic rst,
  input  logic ctl_wr,
  input  logic ctl_en_in,
  input  logic ctl_dir_in,
  input  logic hb_stb,
  input  logic hb_dir,
  input  logic dn_rdy,
  output logic dma_req,
  output logic stat_dreq,
  output logic cfg_en,
  output logic cfg_dir,
  output logic err_flag
);
  localparam int unsigned CW = (BYTES > 1) ? $clog2(BYTES) : 1;

  xfer_dir_e     dir_q;
  logic          count_ok;
  logic          wrap;
  logic [CW-1:0] cnt;
  logic          clr;

  assign clr = ctl_wr || !cfg_en;

  dmarq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr       (ctl_wr),
    .en_in    (ctl_en_in),
    .dir_in   (ctl_dir_in),
    .stb      (hb_stb),
    .stb_dir  (hb_dir),
    .mid_word (cnt != '0),
    .en       (cfg_en),
    .dir      (dir_q),
    .count_ok (count_ok),
    .err      (err_flag)
  );

  dmarq_counter #(.BYTES(BYTES)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .inc  (count_ok),
    .cnt  (cnt),
    .wrap (wrap)
  );

  dmarq_reqgen u_req (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .inc       (count_ok),
    .word_done (wrap),
    .rdy       (dn_rdy),
    .req       (dma_req)
  );

  assign cfg_dir   = dir_q;
  assign stat_dreq = dma_req;
endmodule

// File: rtl/dmarq_checker.sv
module dmarq_checker (
  input logic clk,
  input logic rst,
  input logic ctl_wr,
  input logic hb_stb,
  input logic hb_dir,
  input logic dn_rdy,
  input logic dma_req,
  input logic cfg_en,
  input logic cfg_dir,
  input logic err_flag
);
  // R7: request only while enabled
  p_req_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> cfg_en);

  // R3: a rising request is always preceded by a ready pulse
  p_rise_after_rdy_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req) |-> $past(dn_rdy));

  // R4: a counted byte while requesting drops the request
  p_drop_on_byte_r4: assert property (@(posedge clk) disable iff (rst)
    (dma_req && hb_stb && (hb_dir == cfg_dir) && !ctl_wr) |=> !dma_req);

  // R6: control write clears request and error
  p_ctlwr_clears_r6: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (!dma_req && !err_flag));

  // R9: error is sticky until a control write
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !ctl_wr) |=> err_flag);
endmodule

bind dmarq_top dmarq_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .ctl_wr   (ctl_wr),
  .hb_stb   (hb_stb),
  .hb_dir   (hb_dir),
  .dn_rdy   (dn_rdy),
  .dma_req  (dma_req),
  .cfg_en   (cfg_en),
  .cfg_dir  (cfg_dir),
  .err_flag (err_flag)
);

// File: tb/tb_dmarq_top.sv
module tb_dmarq_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 0, ctl_en_in = 0, ctl_dir_in = 0;
  logic hb_stb = 0, hb_dir = 0, dn_rdy = 0;
  logic dma_req, stat_dreq, cfg_en, cfg_dir, err_flag;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dmarq_top dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_en_in(ctl_en_in),
    .ctl_dir_in(ctl_dir_in), .hb_stb(hb_stb), .hb_dir(hb_dir),
    .dn_rdy(dn_rdy), .dma_req(dma_req), .stat_dreq(stat_dreq),
    .cfg_en(cfg_en), .cfg_dir(cfg_dir), .err_flag(err_flag)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic ctl(logic en, logic dir);
    ctl_wr = 1; ctl_en_in = en; ctl_dir_in = dir;
    @(posedge clk); #1;
    ctl_wr = 0;
  endtask

  task automatic bytes(int n, logic dir);
    for (int i = 0; i < n; i++) begin
      hb_stb = 1; hb_dir = dir;
      @(posedge clk); #1;
      hb_stb = 0;
    end
  endtask

  task automatic rdy();
    dn_rdy = 1;
    @(posedge clk); #1;
    dn_rdy = 0;
  endtask

  task automatic t_reset();
    chk("R1", "en", cfg_en, 0);
    chk("R1", "dir", cfg_dir, 0);
    chk("R1", "req", dma_req, 0);
    chk("R1", "stat", stat_dreq, 0);
    chk("R1", "err", err_flag, 0);
  endtask

  task automatic t_basic_rx();
    ctl(1, 0);
    chk("R2", "en loaded", cfg_en, 1);
    chk("R10", "dir rx", cfg_dir, 0);
    bytes(3, 0); rdy();
    chk("R3", "stray rdy ignored", dma_req, 0);
    bytes(1, 0);
    chk("R3", "no req before rdy", dma_req, 0);
    idle(3);
    chk("R3", "still waiting", dma_req, 0);
    rdy();
    chk("R3", "req after rdy", dma_req, 1);
    chk("R8", "stat mirrors high", stat_dreq, 1);
    bytes(1, 0);
    chk("R4", "req drops on next byte", dma_req, 0);
    chk("R8", "stat mirrors low", stat_dreq, 0);
    bytes(2, 0); rdy();
    chk("R4", "wrap needs 4 fresh", dma_req, 0);
    bytes(1, 0); rdy();
    chk("R4", "second word req", dma_req, 1);
  endtask

  task automatic t_ignore_err();
    ctl(1, 0);
    chk("R6", "ctl write clears req", dma_req, 0);
    bytes(2, 1);
    chk("R9", "no err at word start", err_flag, 0);
    bytes(2, 0); bytes(1, 1);
    chk("R9", "err mid-word", err_flag, 1);
    bytes(2, 0); rdy();
    chk("R5", "wrong dir not counted", dma_req, 1);
    chk("R9", "err sticky", err_flag, 1);
  endtask

  task automatic t_restart();
    ctl(1, 0);
    chk("R6", "err cleared", err_flag, 0);
    bytes(2, 0);
    ctl(1, 0);
    bytes(3, 0); rdy();
    chk("R6", "restart cleared count", dma_req, 0);
    bytes(1, 0); rdy();
    chk("R6", "req after restart", dma_req, 1);
  endtask

  task automatic t_tx();
    ctl(1, 1);
    chk("R10", "dir tx", cfg_dir, 1);
    bytes(4, 0); rdy();
    chk("R5", "rx bytes ignored in tx", dma_req, 0);
    bytes(4, 1); rdy();
    chk("R10", "tx req", dma_req, 1);
  endtask

  task automatic t_disable();
    ctl(0, 1);
    chk("R7", "en cleared", cfg_en, 0);
    chk("R7", "req cleared", dma_req, 0);
    bytes(4, 1); rdy();
    chk("R7", "no req while disabled", dma_req, 0);
    bytes(1, 1); bytes(1, 0);
    chk("R9", "no err while disabled", err_flag, 0);
    ctl(1, 1); bytes(4, 1); rdy();
    chk("R5", "disabled bytes not counted", dma_req, 1);
  endtask

  initial begin
    idle(3);
    rst = 0;
    #1;
    t_reset();
    t_basic_rx();
    t_ignore_err();
    t_restart();
    t_tx();
    t_disable();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule